// File: doc/BRIEF.md
# First-Order Delta-Sigma Requantizer

This block takes a stream of wide signed PCM words and turns each one into a short code of one or a few bits. Each code is produced in the same transfer as its sample. A first-order noise-shaping loop does the conversion. Each accepted sample, minus the value of the last emitted code, is added into a running accumulator. The new code is the upper slice of that accumulator, kept in a narrow register. The same register drives the output and, on the next sample, the feedback. The long-run average of the emitted levels follows the input. The quantization error reaches the output only after a first difference (1 − z⁻¹), which moves its energy towards high frequencies. With one output bit the result is a pulse-density stream.

Both sides of the block are valid/ready streams. A sample moves in when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. So back-pressure from `out_ready` reaches the input with no extra cycle, and no sample is ever dropped or doubled. The loop moves forward only on accepted samples, so stalls and gaps change the timing of the code stream but never its content. A synchronous active-high reset clears the loop and the output stage.

Top module: `dsq_requantizer`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `out_valid` = 0 and `out_code` = 0. The accumulator and the feedback value are both cleared.
- R2: The first sample accepted after reset sees a feedback of zero. Its code is therefore the quantizer's decision on the sample itself. In the 1-bit case that code is 1 exactly when the sample is non-negative.
- R3: For accepted samples x_k (k = 0, 1, …), the accumulator obeys u_k = u_(k−1) + x_k − L(c_(k−1)) and the code is c_k = Q(u_k), with u_(−1) = 0 and zero feedback before the first code. Here W = `DATA_W`, B = `CODE_W`, and codes are unsigned.
- R4: The level of code c is L(c) = (2c + 1 − 2^B)·2^(W−B). The quantizer is Q(u) = clamp(floor(u / 2^(W−B+1)) + 2^(B−1), 0, 2^B − 1). So for B = 1, code 1 is +2^(W−1) and code 0 is −2^(W−1).
- R5: The code for an accepted sample is on `out_code`, with `out_valid` = 1, in the cycle right after the accepting edge.
- R6: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` holds its value. An output taken with no new sample leaves `out_valid` low.
- R7: On cycles with no input transfer the accumulator and feedback do not move. The code sequence therefore depends only on the sequence of accepted samples, not on gaps or stalls.
- R8: For every W-bit input sequence, the accumulator stays within [−(2^(W−1) + 2^(W−B)), 2^(W−1) + 2^(W−B)). It uses W+2 bits and never wraps, even at either full-scale input held forever.
- R9: For B = 1 and a constant input x, every window of 2^W consecutive codes taken after the first holds a number of ones within ±1 of x + 2^(W−1).
- R10: For B > 1 and a constant input x, the sum of L(c) over any 2^W consecutive codes after the first differs from 2^W·x by less than 2^W + 2^(W−B+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed two's-complement input sample |
| out_valid | output | 1 | `out_code` holds a code not yet taken |
| out_ready | input | 1 | Downstream takes the code this cycle |
| out_code | output | CODE_W | Unsigned quantizer code, level per R4 |

## Verification
The hardest state to reach is the accumulator at the edge of its range, where a wrap would flip the sign of the feedback. Only a full-scale input held for many samples drives it there. The stimulus therefore sweeps every constant input of a 6-bit configuration, including both extremes, for a full 2^W window each. It does this for a 1-bit and a 2-bit quantizer side by side. A second hard case is proving that the loop stays frozen while the output is held. For this, irregular `out_ready` and `in_valid` patterns are overlaid on a changing input, and every emitted code is compared against an arithmetic model that ignores timing.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  // Quantizer structure selected from the code width.
  typedef enum logic [0:0] {
    QZ_SIGN  = 1'b0,  // single bit: sign of the accumulator
    QZ_SLICE = 1'b1   // several bits: clamped upper slice of the accumulator
  } qz_kind_e;

  function automatic qz_kind_e pick_kind(input int code_w);
    return (code_w == 1) ? QZ_SIGN : QZ_SLICE;
  endfunction

  // Magnitude bound of the accumulator for any input of data_w bits.
  function automatic int acc_limit(input int data_w, input int code_w);
    return (1 << (data_w - 1)) + (1 << (data_w - code_w));
  endfunction

endpackage

// File: rtl/dsq_level_map.sv
// Maps an unsigned code onto its odd-symmetric feedback level, in input units,
// sign-extended to the accumulator width.
module dsq_level_map #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 1,
  parameter int ACC_W  = DATA_W + 2
) (
  input  logic        [CODE_W-1:0] code,
  output logic signed [ACC_W-1:0]  level
);
  localparam int SH = DATA_W - CODE_W;

  logic signed [ACC_W-1:0] odd_mult;

  // 2c + 1 - 2^B, always odd, within [-(2^B - 1), 2^B - 1]
  assign odd_mult = $signed({{(ACC_W-CODE_W-1){1'b0}}, code, 1'b1})
                  - $signed(ACC_W'(1 << CODE_W));
  assign level    = odd_mult <<< SH;

endmodule

// File: rtl/dsq_quantizer.sv
// Reduces the accumulator to a code by keeping its upper bits.
module dsq_quantizer #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 1,
  parameter int ACC_W  = DATA_W + 2
) (
  input  logic signed [ACC_W-1:0]  acc_val,
  output logic        [CODE_W-1:0] code
);
  import dsq_pkg::*;

  localparam int       SHIFT    = DATA_W - CODE_W + 1;
  localparam int       SL_W     = ACC_W - SHIFT;
  localparam int       CODE_MAX = (1 << CODE_W) - 1;
  localparam qz_kind_e KIND     = pick_kind(CODE_W);

  generate
    if (KIND == QZ_SIGN) begin : g_sign
      logic unused_mag_bits;
      assign unused_mag_bits = ^acc_val[ACC_W-2:0];
      assign code = ~acc_val[ACC_W-1];
    end else begin : g_slice
      logic unused_low_bits;
      logic signed [SL_W:0] biased;
      assign unused_low_bits = ^acc_val[SHIFT-1:0];
      always_comb begin
        biased = {acc_val[ACC_W-1], acc_val[ACC_W-1:SHIFT]}
               + (SL_W+1)'(1 << (CODE_W - 1));
        if (biased < 0)
          code = '0;
        else if (biased > CODE_MAX)
          code = CODE_W'(CODE_MAX);
        else
          code = biased[CODE_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/dsq_integrator.sv
// Difference node and accumulator of the loop.
module dsq_integrator #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = DATA_W + 2,
  parameter int LIMIT  = 1 << DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [ACC_W-1:0]  feedback,
  output logic signed [ACC_W-1:0]  sum_next,
  output logic signed [ACC_W-1:0]  acc_q
);
  logic signed [ACC_W-1:0] sample_ext;

  assign sample_ext = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};
  assign sum_next   = acc_q + sample_ext - feedback;

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (step_en)
      acc_q <= sum_next;
  end

  // R8
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= -LIMIT) && (acc_q < LIMIT));

endmodule

// File: rtl/dsq_requantizer.sv
module dsq_requantizer #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic        [CODE_W-1:0] out_code
);
  import dsq_pkg::*;

  localparam int ACC_W     = DATA_W + 2;
  localparam int ACC_LIMIT = acc_limit(DATA_W, CODE_W);

  logic                    take;
  logic                    out_valid_q;
  logic                    primed_q;
  logic [CODE_W-1:0]       code_q;
  logic [CODE_W-1:0]       code_next;
  logic signed [ACC_W-1:0] level;
  logic signed [ACC_W-1:0] feedback;
  logic signed [ACC_W-1:0] sum_next;
  logic signed [ACC_W-1:0] acc_q;

  assign in_ready  = !out_valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = out_valid_q;
  assign out_code  = code_q;

  // Feedback is the registered output code in input units; zero until the
  // first code exists.
  assign feedback  = primed_q ? level : '0;

  dsq_level_map #(.DATA_W(DATA_W), .CODE_W(CODE_W), .ACC_W(ACC_W)) u_level (
    .code  (code_q),
    .level (level)
  );

  dsq_integrator #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LIMIT(ACC_LIMIT)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .step_en  (take),
    .sample   (in_data),
    .feedback (feedback),
    .sum_next (sum_next),
    .acc_q    (acc_q)
  );

  dsq_quantizer #(.DATA_W(DATA_W), .CODE_W(CODE_W), .ACC_W(ACC_W)) u_quant (
    .acc_val (sum_next),
    .code    (code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      code_q      <= '0;
      primed_q    <= 1'b0;
    end else if (take) begin
      out_valid_q <= 1'b1;
      code_q      <= code_next;
      primed_q    <= 1'b1;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_code == '0)));

  // R5
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R7
  loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(acc_q));

  generate
    if (CODE_W == 1) begin : g_first_chk
      // R2
      first_code_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !primed_q) |=> (out_code[0] == !$past(in_data[DATA_W-1])));
    end
  endgenerate

endmodule

// File: tb/dsq_requantizer_test.sv
`timescale 1ns/1ps
module dsq_requantizer_test;
  localparam int W = 6;
  localparam int S = 1 << (W - 1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic                out_ready = 1'b1;
  logic                ir1, ov1, ir2, ov2;
  logic [0:0]          oc1;
  logic [1:0]          oc2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int m_acc [2];
  int m_fb  [2];

  always #10 clk = ~clk;

  dsq_requantizer #(.DATA_W(W), .CODE_W(1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir1), .in_data(in_data),
    .out_valid(ov1), .out_ready(out_ready), .out_code(oc1)
  );

  dsq_requantizer #(.DATA_W(W), .CODE_W(2)) uut_multi (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir2), .in_data(in_data),
    .out_valid(ov2), .out_ready(out_ready), .out_code(oc2)
  );

  // Quantizer per R4 as a count of crossed thresholds.
  function automatic int quant(input int u, input int qb);
    int c = 0;
    int h = 1 << (W - qb);
    for (int j = 1; j < (1 << qb); j++)
      if (u >= (j - (1 << (qb - 1))) * 2 * h) c++;
    return c;
  endfunction

  function automatic int level(input int c, input int qb);
    return (2 * c + 1 - (1 << qb)) * (1 << (W - qb));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_acc[i] = 0;
      m_fb[i]  = 0;
    end
  endtask

  task automatic model_step(input int i, input int x, output int c);
    m_acc[i] = m_acc[i] + x - m_fb[i];
    c        = quant(m_acc[i], i + 1);
    m_fb[i]  = level(c, i + 1);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp, input int tol);
    int diff;
    n_checks++;
    diff = act - exp;
    if (diff > tol || diff < -tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic step_cycle(input bit iv, input int x, input bit rdy, input string tag,
                            output int c1, output int c2);
    bit was_ov;
    bit took;
    int held1, held2, e1, e2;
    was_ov    = ov1;
    held1     = int'(oc1);
    held2     = int'(oc2);
    in_valid  = iv;
    in_data   = W'(x);
    out_ready = rdy;
    #1;
    check("R6", int'(ir1), int'(!was_ov || rdy));
    took = iv && (!was_ov || rdy);
    e1 = 0;
    e2 = 0;
    if (took) begin
      model_step(0, x, e1);
      model_step(1, x, e2);
    end
    @(negedge clk);
    if (took) begin
      check("R5", int'(ov1), 1);
      check(tag, int'(oc1), e1);
      check("R4", int'(oc2), e2);
    end else if (was_ov && !rdy) begin
      check("R6", int'(ov1), 1);
      check("R6", int'(oc1), held1);
      check("R6", int'(oc2), held2);
    end else begin
      check("R6", int'(ov1), 0);
    end
    c1 = int'(oc1);
    c2 = int'(oc2);
  endtask

  task automatic do_reset();
    rst      = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check("R1", int'(ov1), 0);
    check("R1", int'(oc1), 0);
    check("R1", int'(ov2), 0);
    check("R1", int'(oc2), 0);
    check("R1", int'(ir1), 1);
  endtask

  initial begin
    int c1, c2, ones, lsum;
    @(negedge clk);
    do_reset();

    // Every constant input, full window each: R2, R3, R4, R8, R9, R10.
    for (int x = -S; x < S; x++) begin
      do_reset();
      ones = 0;
      lsum = 0;
      for (int k = 0; k <= 2 * S; k++) begin
        string tag;
        if (k == 0) tag = "R2";
        else if (x == -S || x == S - 1) tag = "R8";
        else tag = "R3";
        step_cycle(1'b1, x, 1'b1, tag, c1, c2);
        if (k >= 1) begin
          ones += c1;
          lsum += level(c2, 2);
        end
      end
      check_near("R9", ones, x + S, 1);
      check_near("R10", lsum, 2 * S * x, 2 * S + 2 * (1 << (W - 2)) - 1);
    end

    // Changing input, unbroken stream: R3.
    do_reset();
    for (int k = 0; k < 192; k++)
      step_cycle(1'b1, ((k * 7) % (2 * S)) - S, 1'b1, "R3", c1, c2);

    // Gaps and back-pressure on a changing input: R6, R7.
    for (int k = 0; k < 400; k++)
      step_cycle((k % 5) != 2, ((k * 13) % (2 * S)) - S,
                 ((k % 3) != 0) && ((k % 7) != 4), "R7", c1, c2);
    step_cycle(1'b0, 0, 1'b1, "R7", c1, c2);

    // Reset while a code is held, then a fresh start: R1, R2.
    step_cycle(1'b1, 17, 1'b0, "R3", c1, c2);
    step_cycle(1'b1, 9, 1'b0, "R6", c1, c2);
    do_reset();
    step_cycle(1'b1, -5, 1'b1, "R2", c1, c2);
    step_cycle(1'b1, 3, 1'b1, "R3", c1, c2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual 150000 cycles expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule